// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable logic device. It has eight macrocells. Each one takes the sum-of-products result for its pin and an enable product term from the logic array. It drives one three-state output pin and returns a feedback bit to the array. The whole bank runs in one of three operating modes, chosen by two global configuration bits. Each cell also has its own polarity bit and its own I/O configuration bit.

The mode decides three things. It decides whether the two shared device pins act as a register clock and a common output enable, or as plain inputs. It decides whether each cell is a flip-flop, a plain output or an input. It decides where each feedback bit comes from: the cell's own pin, a neighbouring pin, the flip-flop, or one of the shared pins.

Pins are modelled as three separate signals: a drive enable, a driven value and an externally applied level. The level of a pin is its driven value when the cell drives it, and the external level otherwise. The shared clock pin is sampled by the system clock, and a low-to-high change seen there loads the flip-flops. Cells are numbered 0 to 7 along the pin row. Cells 3 and 4 are the two centre cells, and cells 0 and 7 are the two ends.

Top module: `olmc_bank`

## Requirements
- R1: The mode comes from the bits {cfg_syn, cfg_ac0}. Code 2'b10 selects simple mode, 2'b11 selects complex mode and 2'b01 selects registered mode. The unused code 2'b00 behaves exactly like simple mode.
- R2: The polarity bit sets the cell's data value before the flip-flop or the pin. The value is the sum-of-products when cell_xor=1 and its inverse when cell_xor=0. This holds in every mode.
- R3: In simple mode, a cell with cell_ac1=0 always drives its pin and a cell with cell_ac1=1 never drives it. Centre cells 3 and 4 always drive their pins, whatever their cell_ac1 bit is.
- R4: In simple mode, cells 0 to 2 feed back the pin level of cell i+1 and cells 5 to 7 feed back the pin level of cell i-1. Cells 3 and 4 always feed back 0.
- R5: In complex mode, a cell with cell_ac1=1 drives its pin exactly when its pt_oe bit is 1. A cell with cell_ac1=0 never drives its pin.
- R6: In complex mode, cells 1 to 6 feed back their own pin level, which is the external level when the pin is not driven. Cell 0 feeds back clk_pin and cell 7 feeds back oe_pin.
- R7: In registered mode, a cell with cell_ac1=0 is a flip-flop. It loads its data value on a system clock edge that finds clk_pin high after it was low on the previous edge, and it holds its value otherwise. It drives its pin with the flip-flop value exactly when oe_pin is 0.
- R8: In registered mode, the feedback of a flip-flop cell is the inverse of its flip-flop value, whatever the pin is doing.
- R9: In registered mode, a cell with cell_ac1=1 is combinational. It drives its pin when pt_oe is 1, and it feeds back its own pin level.
- R10: A synchronous reset clears every flip-flop and the clk_pin edge detector. Right after reset, registered mode therefore drives 0 on the flip-flop cells and feeds back 1 from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_syn | input | 1 | Global mode bit (upper) |
| cfg_ac0 | input | 1 | Global mode bit (lower) |
| cell_xor | input | 8 | Per-cell polarity bit |
| cell_ac1 | input | 8 | Per-cell I/O configuration bit |
| sop | input | 8 | Sum-of-products result per cell |
| pt_oe | input | 8 | Enable product term per cell |
| clk_pin | input | 1 | Shared pin: register clock, or a data input in complex mode |
| oe_pin | input | 1 | Shared pin: active-low common enable, or a data input in complex mode |
| pin_in | input | 8 | External level on each cell's pin |
| pin_out | output | 8 | Value driven onto each pin |
| pin_drive | output | 8 | Drive enable for each pin |
| fb | output | 8 | Feedback bit per cell into the logic array |

## Verification
The bench builds the bank with its default width of eight cells. At that width the two centre cells (3 and 4), the two end cells (0 and 7) and the interior cells all appear in every mode. This covers every case of the routing rules: neighbour feedback, cells with no feedback, and feedback taken from a shared pin. The bench applies every mode code, including the unused one, with all-zero, all-one and mixed polarity masks. It then runs clock-pin sequences that show a flip-flop loading on the rising edge, holding while the clock pin stays high, and going undriven when oe_pin is high.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'd0,
        MODE_COMPLEX    = 2'd1,
        MODE_REGISTERED = 2'd2
    } bank_mode_e;

    // Global bit pair to bank mode; the unused code falls back to simple.
    function automatic bank_mode_e decode_mode(input logic syn, input logic ac0);
        case ({syn, ac0})
            2'b11:   return MODE_COMPLEX;
            2'b01:   return MODE_REGISTERED;
            default: return MODE_SIMPLE;
        endcase
    endfunction

    // Polarity stage: 1 passes the sum-of-products, 0 inverts it.
    function automatic logic apply_polarity(input logic sop_bit, input logic pol_bit);
        return pol_bit ? sop_bit : ~sop_bit;
    endfunction

endpackage

// File: rtl/olmc_edge.sv
module olmc_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    assign rise = pin & ~prev_q;

    // A detected rise cannot repeat on the very next edge.
    assert_single_rise_R7: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
#(
    parameter bit IS_CENTRE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_mode_e mode,
    input  logic       pol_bit,
    input  logic       io_bit,
    input  logic       sop_bit,
    input  logic       pt_en,
    input  logic       oe_pin,
    input  logic       load,
    output logic       drive,
    output logic       value,
    output logic       reg_fb
);
    logic d;
    logic q;

    assign d = apply_polarity(sop_bit, pol_bit);

    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= d;
    end

    assign reg_fb = ~q;

    always_comb begin
        value = d;
        case (mode)
            MODE_COMPLEX: drive = io_bit & pt_en;
            MODE_REGISTERED: begin
                if (!io_bit) begin
                    drive = ~oe_pin;
                    value = q;
                end else begin
                    drive = pt_en;
                end
            end
            default: drive = IS_CENTRE ? 1'b1 : ~io_bit;
        endcase
    end

    assert_reg_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));
    assert_reg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
    assert_centre_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SIMPLE && IS_CENTRE) |-> drive);
    assert_complex_input_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMPLEX && !io_bit) |-> !drive);

endmodule

// File: rtl/olmc_fb_route.sv
module olmc_fb_route
    import olmc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  bank_mode_e   mode,
    input  logic [N-1:0] pin_level,
    input  logic [N-1:0] reg_fb,
    input  logic [N-1:0] io_bits,
    input  logic         clk_pin,
    input  logic         oe_pin,
    output logic [N-1:0] fb
);
    localparam int CTR_LO = N/2 - 1;
    localparam int CTR_HI = N/2;

    logic [N-1:0] simple_src;
    logic [N-1:0] complex_src;

    for (genvar i = 0; i < N; i++) begin : g_route
        if (i < CTR_LO) begin : g_outer_lo
            assign simple_src[i] = pin_level[i+1];
        end else if (i > CTR_HI) begin : g_outer_hi
            assign simple_src[i] = pin_level[i-1];
        end else begin : g_centre
            assign simple_src[i] = 1'b0;
        end

        if (i == 0) begin : g_first
            assign complex_src[i] = clk_pin;
        end else if (i == N-1) begin : g_last
            assign complex_src[i] = oe_pin;
        end else begin : g_mid
            assign complex_src[i] = pin_level[i];
        end
    end

    always_comb begin
        case (mode)
            MODE_COMPLEX:    fb = complex_src;
            MODE_REGISTERED: fb = (reg_fb & ~io_bits) | (pin_level & io_bits);
            default:         fb = simple_src;
        endcase
    end

    assert_centre_fb_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SIMPLE) |-> (fb[CTR_LO] == 1'b0 && fb[CTR_HI] == 1'b0));
    assert_shared_pins_fb_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMPLEX) |-> (fb[0] == clk_pin && fb[N-1] == oe_pin));

endmodule

// File: rtl/olmc_bank.sv
module olmc_bank
    import olmc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_syn,
    input  logic         cfg_ac0,
    input  logic [N-1:0] cell_xor,
    input  logic [N-1:0] cell_ac1,
    input  logic [N-1:0] sop,
    input  logic [N-1:0] pt_oe,
    input  logic         clk_pin,
    input  logic         oe_pin,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_drive,
    output logic [N-1:0] fb
);
    localparam int CTR_LO = N/2 - 1;
    localparam int CTR_HI = N/2;

    bank_mode_e   mode;
    logic         load;
    logic [N-1:0] reg_fb;
    logic [N-1:0] pin_level;

    assign mode = decode_mode(cfg_syn, cfg_ac0);

    olmc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (clk_pin),
        .rise (load)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        olmc_cell #(
            .IS_CENTRE ((i == CTR_LO) || (i == CTR_HI))
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .pol_bit (cell_xor[i]),
            .io_bit  (cell_ac1[i]),
            .sop_bit (sop[i]),
            .pt_en   (pt_oe[i]),
            .oe_pin  (oe_pin),
            .load    (load),
            .drive   (pin_drive[i]),
            .value   (pin_out[i]),
            .reg_fb  (reg_fb[i])
        );

        assign pin_level[i] = pin_drive[i] ? pin_out[i] : pin_in[i];

        assert_reg_enable_R7: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_REGISTERED && !cell_ac1[i]) |-> (pin_drive[i] == !oe_pin));
        assert_reg_fb_R8: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_REGISTERED && !cell_ac1[i]) |-> (fb[i] == !pin_out[i]));
    end

    olmc_fb_route #(.N(N)) u_route (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .pin_level (pin_level),
        .reg_fb    (reg_fb),
        .io_bits   (cell_ac1),
        .clk_pin   (clk_pin),
        .oe_pin    (oe_pin),
        .fb        (fb)
    );

endmodule

// File: tb/sim_olmc_bank.sv
module sim_olmc_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_syn = 1'b0, cfg_ac0 = 1'b1;
    logic [7:0] cell_xor = '0, cell_ac1 = '0, sop = '0, pt_oe = '0, pin_in = '0;
    logic       clk_pin = 1'b0, oe_pin = 1'b0;
    logic [7:0] pin_out, pin_drive, fb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] drv;
        logic [7:0] out;
        logic [7:0] fbk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // Bench-side register model
    logic [7:0] mq = '0;
    logic       mprev = 1'b0;

    always #5 clk = ~clk;

    olmc_bank u0 (
        .clk(clk), .rst(rst), .cfg_syn(cfg_syn), .cfg_ac0(cfg_ac0),
        .cell_xor(cell_xor), .cell_ac1(cell_ac1), .sop(sop), .pt_oe(pt_oe),
        .clk_pin(clk_pin), .oe_pin(oe_pin), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive(pin_drive), .fb(fb)
    );

    function automatic exp_t model();
        exp_t e;
        logic [7:0] d, lvl;
        d = ~(sop ^ cell_xor);
        for (int i = 0; i < 8; i++) begin
            case ({cfg_syn, cfg_ac0})
                2'b11: begin e.drv[i] = cell_ac1[i] & pt_oe[i]; e.out[i] = d[i]; end
                2'b01: begin
                    if (!cell_ac1[i]) begin e.drv[i] = ~oe_pin; e.out[i] = mq[i]; end
                    else begin e.drv[i] = pt_oe[i]; e.out[i] = d[i]; end
                end
                default: begin
                    e.drv[i] = (i == 3 || i == 4) ? 1'b1 : ~cell_ac1[i];
                    e.out[i] = d[i];
                end
            endcase
        end
        lvl = (e.drv & e.out) | (~e.drv & pin_in);
        for (int i = 0; i < 8; i++) begin
            case ({cfg_syn, cfg_ac0})
                2'b11: e.fbk[i] = (i == 0) ? clk_pin : (i == 7) ? oe_pin : lvl[i];
                2'b01: e.fbk[i] = cell_ac1[i] ? lvl[i] : ~mq[i];
                default: e.fbk[i] = (i < 3) ? lvl[i+1] : (i > 4) ? lvl[i-1] : 1'b0;
            endcase
        end
        return e;
    endfunction

    // Driver: waits for an edge, advances the model, applies stimulus, queues expectation.
    task automatic step(input logic syn, input logic ac0, input logic [7:0] xr,
                        input logic [7:0] ac1, input logic [7:0] s, input logic [7:0] pt,
                        input logic [7:0] pin, input logic p1, input logic p11,
                        input string tag);
        @(posedge clk);
        #2;
        if (clk_pin && !mprev) mq = ~(sop ^ cell_xor);
        mprev = clk_pin;
        cfg_syn = syn; cfg_ac0 = ac0; cell_xor = xr; cell_ac1 = ac1;
        sop = s; pt_oe = pt; pin_in = pin; clk_pin = p1; oe_pin = p11;
        exp_q.push_back(model());
        tag_q.push_back(tag);
    endtask

    // Monitor: compares at the falling edge after each stimulus
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pin_drive !== e.drv) begin
                errors++;
                $display("FAIL %s drive act=%h exp=%h", t, pin_drive, e.drv);
            end
            checks++;
            if ((pin_out & e.drv) !== (e.out & e.drv)) begin
                errors++;
                $display("FAIL %s out act=%h exp=%h", t, pin_out & e.drv, e.out & e.drv);
            end
            checks++;
            if (fb !== e.fbk) begin
                errors++;
                $display("FAIL %s fb act=%h exp=%h", t, fb, e.fbk);
            end
        end
    end

    initial begin
        logic [7:0] xs[3];
        logic [7:0] acs[4];
        xs  = '{8'h00, 8'hFF, 8'h5A};
        acs = '{8'h00, 8'hFF, 8'h96, 8'h3C};
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R10: flip-flops cleared by reset, registered mode with clock pin idle
        step(1'b0, 1'b1, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, "R10");
        // Every mode code, polarity mask and configuration pattern
        for (int m = 0; m < 4; m++) begin
            for (int x = 0; x < 3; x++) begin
                for (int p = 0; p < 4; p++) begin
                    string t;
                    logic [7:0] s, pt, pin;
                    s   = 8'(m * 53 + p * 29 + x * 17 + 7);
                    pt  = 8'(p * 71 + m * 13 + 5);
                    pin = 8'(x * 97 + p * 41 + 3);
                    case (m)
                        0: t = "R1 R2 R3 R4";
                        1: t = "R1 R2 R7 R8 R9";
                        2: t = "R1 R2 R3 R4";
                        default: t = "R1 R2 R5 R6";
                    endcase
                    step(m[1], m[0], xs[x], acs[p], s, pt, pin, p[0], p[1] ^ x[0], t);
                end
            end
        end
        // R7: load on rise, hold while high, reload on next rise, float on oe_pin high
        step(1'b0, 1'b1, 8'hFF, 8'h00, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 8'hFF, 8'h00, 8'hA5, 8'h00, 8'h00, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 8'hFF, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b0, "R7 R8");
        step(1'b0, 1'b1, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b0, "R7 R8");
        step(1'b0, 1'b1, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b0, "R2 R7");
        step(1'b0, 1'b1, 8'h00, 8'h00, 8'h3C, 8'h00, 8'hFF, 1'b1, 1'b1, "R7 R8");
        // R9: combinational cells mixed with flip-flop cells
        step(1'b0, 1'b1, 8'h0F, 8'hF0, 8'h66, 8'hA0, 8'h55, 1'b0, 1'b0, "R9");
        // R6: both shared pins read back through end cells, interior pins floating
        step(1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h7E, 1'b1, 1'b1, "R5 R6");
        // R3/R4: all cells as inputs in simple mode, centre cells still driven
        step(1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h81, 1'b0, 1'b0, "R3 R4");
        // R1: unused code matches simple mode
        step(1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h81, 1'b0, 1'b0, "R1");
        @(posedge clk);
        @(negedge clk);
        #1 done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule